// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the two access ports of a dual-port memory. When both ports are selected and point at the same word, it decides which port owns the word. The other port gets an active-low busy flag, and its writes are suppressed inside the block. Arrival order is counted in whole clock cycles. A port that has held the same address with its select low since an earlier cycle is "settled". On a fresh collision, a settled port beats a port that has just arrived. If neither port is settled, or both are, the left port wins.

The decision is registered. Busy appears one clock edge after the collision is seen. It stays in place for as long as the addresses keep matching, and it is released one edge after the match ends. The next collision is then arbitrated afresh. Each port's qualified write enable is a combinational function of that port's select, its write strobe and its effective busy level.

In master mode the block computes busy itself and drives both busy outputs. In slave mode it does not arbitrate. Its busy outputs stay high, and the two busy inputs, supplied by a master elsewhere, act only as write inhibits.

Top module: `dp_collide_arb`

## Requirements
- R1: After reset, both busy outputs are high (1), and with both selects high both write enables are low (0).
- R2: Contention exists only when both selects are low and the two addresses are bit-for-bit equal, including the all-ones address. Otherwise both busy outputs are high at the next edge.
- R3: On a fresh collision where exactly one port is settled (selected at the same address on the previous edge), the newly arrived port gets busy low at the next edge. The settled port keeps busy high.
- R4: On a fresh collision where neither port is settled, or both are, the right port gets busy low and the left port keeps busy high.
- R5: The two busy outputs are never low at the same time.
- R6: Busy is held while the addresses keep matching with both selects low. It is released at the first edge after the match ends. A later collision is arbitrated again under R3 and R4.
- R7: A port's write enable is high only when its select is low, its write strobe is low and its effective busy is high. A busy port's write strobe therefore has no effect.
- R8: In master mode (mode input 1), the busy inputs have no effect on the write enables.
- R9: In slave mode (mode input 0), both busy outputs stay high. A low busy input blocks that port's writes, whatever the address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (arbitrate, drive busy), 0 = slave (busy is an input) |
| l_cs_ni | input | 1 | Left port select, active low |
| l_addr_i | input | ADDR_W | Left port address |
| l_we_ni | input | 1 | Left port write strobe, active low |
| r_cs_ni | input | 1 | Right port select, active low |
| r_addr_i | input | ADDR_W | Right port address |
| r_we_ni | input | 1 | Right port write strobe, active low |
| l_busy_ni | input | 1 | Left busy from an external master, active low, used in slave mode |
| r_busy_ni | input | 1 | Right busy from an external master, active low, used in slave mode |
| l_busy_no | output | 1 | Left busy, active low |
| r_busy_no | output | 1 | Right busy, active low |
| l_wr_o | output | 1 | Qualified left write enable, active high |
| r_wr_o | output | 1 | Qualified right write enable, active high |

## Verification
The busy outputs change one clock edge after the select and address pattern that causes them. The settled status behind R3 needs one more earlier edge with the same address in place. The write enables follow the present strobes and the present busy level within the same cycle. The bench applies every input change at a falling edge and samples at the following falling edge. By then exactly one rising edge has consumed the new inputs, and busy and the write enables reflect the same cycle. Scenarios that depend on the settled status drive the early port one full cycle ahead of the late one.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int unsigned NPORT  = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;

  // which port is currently blocked
  typedef enum logic [1:0] {
    GR_FREE   = 2'd0,
    GR_L_HELD = 2'd1,
    GR_R_HELD = 2'd2
  } grant_e;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              settled_o
);
  logic              active_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      active_q <= ~cs_ni;
      addr_q   <= addr_i;
    end
  end

  // access began on an earlier cycle and has not moved
  assign settled_o = ~cs_ni & active_q & (addr_q == addr_i);
endmodule

// File: rtl/dpa_grant.sv
module dpa_grant
  import dpa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic match_i,
  input  logic l_settled_i,
  input  logic r_settled_i,
  output logic l_busy_no,
  output logic r_busy_no
);
  grant_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!master_i || !match_i) begin
      state_d = GR_FREE;
    end else if (state_q == GR_FREE) begin
      // later arrival loses; tie goes to left
      if (r_settled_i && !l_settled_i) state_d = GR_L_HELD;
      else                             state_d = GR_R_HELD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GR_FREE;
    else         state_q <= state_d;
  end

  assign l_busy_no = (state_q != GR_L_HELD);
  assign r_busy_no = (state_q != GR_R_HELD);
endmodule

// File: rtl/dpa_wr_gate.sv
module dpa_wr_gate (
  input  logic master_i,
  input  logic cs_ni,
  input  logic we_ni,
  input  logic own_busy_ni,
  input  logic ext_busy_ni,
  output logic wr_o
);
  logic busy_eff_n;

  // pin level ignored in master mode
  assign busy_eff_n = master_i ? own_busy_ni : ext_busy_ni;
  assign wr_o       = ~cs_ni & ~we_ni & busy_eff_n;
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_cs_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_ni,
  input  logic              r_cs_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_ni,
  input  logic              l_busy_ni,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_wr_o,
  output logic              r_wr_o
);
  logic [NPORT-1:0]             cs_n, we_n, ext_busy_n, own_busy_n, settled, wr;
  logic [NPORT-1:0][ADDR_W-1:0] addr;
  logic                         match;

  assign cs_n       = {r_cs_ni, l_cs_ni};
  assign we_n       = {r_we_ni, l_we_ni};
  assign ext_busy_n = {r_busy_ni, l_busy_ni};
  assign addr       = {r_addr_i, l_addr_i};

  assign match = ~cs_n[PORT_L] & ~cs_n[PORT_R] & (addr[PORT_L] == addr[PORT_R]);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cs_ni    (cs_n[p]),
      .addr_i   (addr[p]),
      .settled_o(settled[p])
    );

    dpa_wr_gate u_gate (
      .master_i   (master_i),
      .cs_ni      (cs_n[p]),
      .we_ni      (we_n[p]),
      .own_busy_ni(own_busy_n[p]),
      .ext_busy_ni(ext_busy_n[p]),
      .wr_o       (wr[p])
    );
  end

  dpa_grant u_grant (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .master_i   (master_i),
    .match_i    (match),
    .l_settled_i(settled[PORT_L]),
    .r_settled_i(settled[PORT_R]),
    .l_busy_no  (own_busy_n[PORT_L]),
    .r_busy_no  (own_busy_n[PORT_R])
  );

  assign l_busy_no = own_busy_n[PORT_L] | ~master_i;
  assign r_busy_no = own_busy_n[PORT_R] | ~master_i;
  assign l_wr_o    = wr[PORT_L];
  assign r_wr_o    = wr[PORT_R];
endmodule

// File: rtl/dp_collide_arb_chk.sv
module dp_collide_arb_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              l_cs_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_we_ni,
  input logic              r_cs_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_we_ni,
  input logic              l_busy_ni,
  input logic              r_busy_ni,
  input logic              l_busy_no,
  input logic              r_busy_no,
  input logic              l_wr_o,
  input logic              r_wr_o
);
  logic hit;
  assign hit = !l_cs_ni && !r_cs_ni && (l_addr_i == r_addr_i);

  a_r5_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_no && !r_busy_no));

  a_r2_no_hit_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> (l_busy_no && r_busy_no));

  a_r7_l_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !l_busy_no) |-> !l_wr_o);

  a_r7_r_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !r_busy_no) |-> !r_wr_o);

  a_r9_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no));

  a_r9_slave_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && (!l_busy_ni || !r_busy_ni)) |-> !((!l_busy_ni && l_wr_o) || (!r_busy_ni && r_wr_o)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !r_busy_no && hit) |=> (!master_i || !hit || !r_busy_no));

  a_r7_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_we_ni || l_cs_ni) |-> !l_wr_o);
endmodule

bind dp_collide_arb dp_collide_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dp_collide_arb_test.sv
module dp_collide_arb_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master = 1'b1;
  logic          l_cs_n = 1'b1, r_cs_n = 1'b1;
  logic          l_we_n = 1'b1, r_we_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_bin_n = 1'b1, r_bin_n = 1'b1;
  logic          l_busy_n, r_busy_n, l_wr, r_wr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_collide_arb #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_cs_ni(l_cs_n), .l_addr_i(l_addr), .l_we_ni(l_we_n),
    .r_cs_ni(r_cs_n), .r_addr_i(r_addr), .r_we_ni(r_we_n),
    .l_busy_ni(l_bin_n), .r_busy_ni(r_bin_n),
    .l_busy_no(l_busy_n), .r_busy_no(r_busy_n),
    .l_wr_o(l_wr), .r_wr_o(r_wr)
  );

  // compares {l_busy, r_busy, l_wr, r_wr}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {l_busy_n, r_busy_n, l_wr, r_wr};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%b exp=%b (l_busy r_busy l_wr r_wr)", req, act, exp);
    end
    if (!l_busy_n && !r_busy_n) begin
      failures++;
      $display("FAIL R5: both busy low act=%b exp=not 00", act[3:2]);
    end
  endtask

  task automatic drive(input logic lc, input logic [AW-1:0] la, input logic lw,
                       input logic rc, input logic [AW-1:0] ra, input logic rw);
    l_cs_n = lc; l_addr = la; l_we_n = lw;
    r_cs_n = rc; r_addr = ra; r_we_n = rw;
  endtask

  task automatic idle();
    drive(1, '0, 1, 1, '0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset", 4'b1100);
  endtask

  task automatic t_left_first();
    idle();
    drive(0, 13'd5, 1, 1, '0, 1); @(negedge clk);
    drive(0, 13'd5, 0, 0, 13'd5, 0); @(negedge clk);
    chk("R3 right late gets busy", 4'b1010);
    @(negedge clk);
    chk("R6 busy held", 4'b1010);
    drive(0, 13'd5, 0, 0, 13'd6, 0); @(negedge clk);
    chk("R6 release after mismatch", 4'b1111);
    drive(0, 13'd5, 0, 0, 13'd5, 0); @(negedge clk);
    chk("R6 fresh arbitration", 4'b1010);
  endtask

  task automatic t_right_first();
    idle();
    drive(1, '0, 1, 0, 13'd200, 1); @(negedge clk);
    drive(0, 13'd200, 0, 0, 13'd200, 0); @(negedge clk);
    chk("R3 left late gets busy", 4'b0101);
    drive(0, 13'd200, 0, 0, 13'd200, 1); @(negedge clk);
    chk("R7 busy left no write, right strobe off", 4'b0100);
  endtask

  task automatic t_tie();
    idle();
    drive(0, 13'd7, 0, 0, 13'd7, 0); @(negedge clk);
    chk("R4 tie right busy", 4'b1010);
    idle();
    drive(0, {AW{1'b1}}, 0, 0, {AW{1'b1}}, 0); @(negedge clk);
    chk("R2 all-ones address collides", 4'b1010);
  endtask

  task automatic t_no_match();
    idle();
    drive(0, 13'd3, 0, 0, 13'd4, 0); repeat (2) @(negedge clk);
    chk("R2 different addresses", 4'b1111);
    drive(1, 13'd9, 0, 0, 13'd9, 0); repeat (2) @(negedge clk);
    chk("R2 left deselected", 4'b1101);
    drive(0, 13'd9, 0, 1, 13'd9, 0); repeat (2) @(negedge clk);
    chk("R2 right deselected", 4'b1110);
  endtask

  task automatic t_master_ignores_pin();
    idle();
    l_bin_n = 0; r_bin_n = 0;
    drive(0, 13'd1, 0, 0, 13'd2, 0); @(negedge clk);
    chk("R8 busy inputs ignored in master", 4'b1111);
    l_bin_n = 1; r_bin_n = 1;
  endtask

  task automatic t_slave();
    idle();
    master = 0;
    drive(0, 13'd8, 0, 1, '0, 1); @(negedge clk);
    drive(0, 13'd8, 0, 0, 13'd8, 0); @(negedge clk);
    chk("R9 slave no arbitration", 4'b1111);
    l_bin_n = 0; #1;
    chk("R9 slave left inhibited", 4'b1101);
    l_bin_n = 1; r_bin_n = 0; #1;
    chk("R9 slave right inhibited", 4'b1110);
    r_bin_n = 1;
    master = 1;
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_left_first();
    t_right_first();
    t_tie();
    t_no_match();
    t_master_ignores_pin();
    t_slave();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule